// File: doc/BRIEF.md
# Separate-I/O Burst SRAM Port

This block is the memory side of a burst SRAM with separate input and output data buses. Writes use an input clock pair and reads use an output clock pair. Data moves on both phases of each pair, so one clock period carries a two-word write burst on the data-in bus and a two-word read burst on the data-out bus. The address bus is shared. The read address is presented in the first half of a period and the write address in the second half.

Behind the buses sits one conventional single-port array whose rows are aligned pairs of words. Within each input-clock period it gives the write slot to a pending write commit and the read slot to the read fetch. A read and a write can be issued together every period, with no turnaround gap. A read of the pair that the same period writes is served from the capture registers, so the read returns the new data.

A burst always stays inside its aligned pair. The second word of a burst lives at the first word's address with bit 0 inverted.

Top module: `sio_burst_sram`

## Requirements
- R1: When `wr_sel_n` is low at a `wclk` rise, the first write word is taken from `din` at that rise. The second word and the write address are taken at the next `wclk_n` rise. The first word is stored at the write address A and the second at A with bit 0 inverted. The write commits to the array at the following `wclk` rise.
- R2: When `wr_sel_n` is high at a `wclk` rise, no write is performed and stored data stays unchanged, whatever is on `din` and `addr`.
- R3: When `rd_sel_n` is low at an `rclk` rise, `addr` is taken as the read address A. After the next `rclk` rise, `dout` carries the word stored at A and `dout_valid` is high.
- R4: After the `rclk_n` rise that follows, `dout` carries the word at A with bit 0 inverted, and `dout_valid` stays high.
- R5: In every half period that is not one of the two beats of a read burst, `dout_valid` is low and `dout` holds the last value it drove.
- R6: When a read and a write are issued in the same period, the write takes effect first. A read of the pair being written returns the newly written words.
- R7: A read and a write may be issued in every period without a gap. Each read produces its burst exactly one period later, and no period is lost to bus turnaround.
- R8: The array has a single address port. A write commit uses it only at a `wclk` rise and a read fetch uses it only at a `wclk_n` rise.
- R9: While `rst_n` is low, `dout_valid` is low, `dout` is zero and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Input clock, rising edge takes the first write word and the select inputs |
| wclk_n | input | 1 | Inverted input clock, rising edge takes the second write word and the write address |
| rclk | input | 1 | Output clock, rising edge takes the read address and launches the first read word; assumed in phase with `wclk` |
| rclk_n | input | 1 | Inverted output clock, rising edge launches the second read word |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_sel_n | input | 1 | Active-low write request |
| rd_sel_n | input | 1 | Active-low read request |
| addr | input | ADDR_W | Shared word address: read address in the first half period, write address in the second |
| din | input | DATA_W | Write data, two beats per period |
| dout | output | DATA_W | Read data, two beats per period |
| dout_valid | output | 1 | High during the two beats of a read burst |

## Verification
The embedded assertions check the following on every clock edge:
- a write request always yields a commit one period later, and its absence never does;
- every read request raises the valid flag during its burst, and every idle period leaves it low;
- the output stays frozen across idle half periods;
- the single array port always sits in the write slot at the input clock rise and in the read slot at its inverse.

Only the bench's scenarios can show that the right words arrive in the right beats. That covers wrap order for odd addresses, write-before-read forwarding within one period, ignored data under a deasserted write select, and stored contents surviving long random runs of back-to-back mixed traffic.

// File: rtl/sio_pkg.sv
`timescale 1ns/1ps
package sio_pkg;
    // default geometry: word address width and word width
    localparam int SIO_ADDR_W = 6;
    localparam int SIO_DATA_W = 16;

    // which word of an aligned pair a beat carries
    typedef enum logic {
        BEAT_LEAD  = 1'b0,
        BEAT_TRAIL = 1'b1
    } beat_e;
endpackage

// File: rtl/sio_wr_capture.sv
`timescale 1ns/1ps
module sio_wr_capture #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                  wclk,
    input  logic                  wclk_n,
    input  logic                  rst_n,
    input  logic                  wr_sel_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     din,
    output logic                  wr_en,
    output logic [ADDR_W-2:0]     wr_pair,
    output logic [2*DATA_W-1:0]   wr_data
);
    localparam int PAIR_W = ADDR_W - 1;

    // rising-phase capture: request flag and first word
    typedef struct packed {
        logic              armed;
        logic [DATA_W-1:0] lead;
    } rise_st_t;

    // falling-phase capture: complete burst ready to commit
    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] wa;
        logic [DATA_W-1:0] lead;
        logic [DATA_W-1:0] trail;
    } fall_st_t;

    rise_st_t rise_d, rise_q;
    fall_st_t fall_d, fall_q;

    always_comb begin
        rise_d       = rise_q;
        rise_d.armed = !wr_sel_n;
        if (!wr_sel_n) begin
            rise_d.lead = din;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= rise_d;
        end
    end

    always_comb begin
        fall_d     = fall_q;
        fall_d.vld = rise_q.armed;
        if (rise_q.armed) begin
            fall_d.wa    = addr;
            fall_d.lead  = rise_q.lead;
            fall_d.trail = din;
        end
    end

    always_ff @(posedge wclk_n or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= fall_d;
        end
    end

    // pair row packs the even word low, the odd word high
    assign wr_en   = fall_q.vld;
    assign wr_pair = fall_q.wa[ADDR_W-1:1];
    assign wr_data = fall_q.wa[0] ? {fall_q.lead, fall_q.trail}
                                  : {fall_q.trail, fall_q.lead};

    AST_WR_COMMITS: assert property (@(posedge wclk) disable iff (!rst_n)
        !wr_sel_n |=> wr_en);  // R1
    AST_NO_SPURIOUS_WR: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_sel_n |=> !wr_en);  // R2

    logic unused_pair_w;
    assign unused_pair_w = (PAIR_W == 0);
endmodule

// File: rtl/sio_array.sv
`timescale 1ns/1ps
module sio_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                  wclk,
    input  logic                  wclk_n,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-2:0]     wr_pair,
    input  logic [2*DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-2:0]     rd_pair,
    output logic [2*DATA_W-1:0]   rd_data
);
    localparam int PAIR_W = ADDR_W - 1;
    localparam int DEPTH  = 1 << PAIR_W;

    typedef struct packed {
        logic                ph_rise;
        logic [2*DATA_W-1:0] rdata;
    } fall_st_t;

    logic                ph_rise_d, ph_rise_q;
    fall_st_t            fall_d, fall_q;
    logic                rd_slot;
    logic [PAIR_W-1:0]   port_pair;
    logic [2*DATA_W-1:0] mem [DEPTH];

    // slot marker: high between the input clock rise and its inverse rise
    assign rd_slot   = ph_rise_q ^ fall_q.ph_rise;
    assign port_pair = rd_slot ? rd_pair : wr_pair;

    always_comb begin
        ph_rise_d = ~ph_rise_q;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            ph_rise_q <= 1'b0;
        end else begin
            ph_rise_q <= ph_rise_d;
        end
    end

    // write slot: one access through the shared port at the input clock rise
    always_ff @(posedge wclk) begin
        if (wr_en && !rd_slot) begin
            mem[port_pair] <= wr_data;
        end
    end

    always_comb begin
        fall_d         = fall_q;
        fall_d.ph_rise = ph_rise_q;
        if (rd_slot) begin
            fall_d.rdata = mem[port_pair];
        end
    end

    always_ff @(posedge wclk_n or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= fall_d;
        end
    end

    assign rd_data = fall_q.rdata;

    AST_WR_SLOT_AT_RISE: assert property (@(posedge wclk) disable iff (!rst_n)
        !rd_slot);  // R8
    AST_RD_SLOT_AT_FALL: assert property (@(posedge wclk_n) disable iff (!rst_n)
        rd_slot);  // R8
endmodule

// File: rtl/sio_rd_launch.sv
`timescale 1ns/1ps
module sio_rd_launch #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                  rclk,
    input  logic                  rclk_n,
    input  logic                  rst_n,
    input  logic                  rd_sel_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [2*DATA_W-1:0]   arr_data,
    input  logic                  fwd_en,
    input  logic [ADDR_W-2:0]     fwd_pair,
    input  logic [2*DATA_W-1:0]   fwd_data,
    output logic [ADDR_W-2:0]     rd_pair,
    output logic [DATA_W-1:0]     dout,
    output logic                  dout_valid
);
    import sio_pkg::*;

    typedef struct packed {
        logic              pend;
        logic [ADDR_W-1:0] ra;
        logic              vld;
        logic [DATA_W-1:0] oq;
        logic [DATA_W-1:0] nxt;
        logic              ph;
    } rise_st_t;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] oq;
        logic              ph;
    } fall_st_t;

    rise_st_t            rise_d, rise_q;
    fall_st_t            fall_d, fall_q;
    logic [2*DATA_W-1:0] pair_sel;
    logic [DATA_W-1:0]   beat_word [2];
    logic                lead_odd;
    logic                out_sel;

    // same-period write to the pair being read wins over the array copy
    assign pair_sel = (fwd_en && (fwd_pair == rise_q.ra[ADDR_W-1:1])) ? fwd_data : arr_data;
    assign lead_odd = rise_q.ra[0];

    for (genvar b = 0; b < 2; b++) begin : g_beat
        localparam beat_e KIND = beat_e'(b);
        // lead beat takes the addressed word, trail beat its pair partner
        assign beat_word[b] = ((KIND == BEAT_TRAIL) ^ lead_odd)
                              ? pair_sel[2*DATA_W-1:DATA_W]
                              : pair_sel[DATA_W-1:0];
    end

    always_comb begin
        rise_d      = rise_q;
        rise_d.pend = !rd_sel_n;
        if (!rd_sel_n) begin
            rise_d.ra = addr;
        end
        rise_d.vld = rise_q.pend;
        rise_d.oq  = rise_q.pend ? beat_word[0] : fall_q.oq;
        if (rise_q.pend) begin
            rise_d.nxt = beat_word[1];
        end
        rise_d.ph = ~rise_q.ph;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
        end else begin
            rise_q <= rise_d;
        end
    end

    always_comb begin
        fall_d     = fall_q;
        fall_d.vld = rise_q.vld;
        fall_d.oq  = rise_q.vld ? rise_q.nxt : rise_q.oq;
        fall_d.ph  = rise_q.ph;
    end

    always_ff @(posedge rclk_n or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= fall_d;
        end
    end

    // first half shows the rise-launched register, second half the fall one
    assign out_sel    = rise_q.ph ^ fall_q.ph;
    assign dout       = out_sel ? rise_q.oq  : fall_q.oq;
    assign dout_valid = out_sel ? rise_q.vld : fall_q.vld;
    assign rd_pair    = rise_q.ra[ADDR_W-1:1];
endmodule

// File: rtl/sio_burst_sram.sv
`timescale 1ns/1ps
module sio_burst_sram #(
    parameter int ADDR_W = sio_pkg::SIO_ADDR_W,
    parameter int DATA_W = sio_pkg::SIO_DATA_W
) (
    input  logic              wclk,
    input  logic              wclk_n,
    input  logic              rclk,
    input  logic              rclk_n,
    input  logic              rst_n,
    input  logic              wr_sel_n,
    input  logic              rd_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    localparam int PAIR_W = ADDR_W - 1;
    localparam int ROW_W  = 2 * DATA_W;

    logic              wr_en;
    logic [PAIR_W-1:0] wr_pair;
    logic [ROW_W-1:0]  wr_data;
    logic [PAIR_W-1:0] rd_pair;
    logic [ROW_W-1:0]  rd_data;

    sio_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wr (
        .wclk     (wclk),
        .wclk_n   (wclk_n),
        .rst_n    (rst_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .din      (din),
        .wr_en    (wr_en),
        .wr_pair  (wr_pair),
        .wr_data  (wr_data)
    );

    sio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_arr (
        .wclk    (wclk),
        .wclk_n  (wclk_n),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_pair (wr_pair),
        .wr_data (wr_data),
        .rd_pair (rd_pair),
        .rd_data (rd_data)
    );

    sio_rd_launch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_rd (
        .rclk       (rclk),
        .rclk_n     (rclk_n),
        .rst_n      (rst_n),
        .rd_sel_n   (rd_sel_n),
        .addr       (addr),
        .arr_data   (rd_data),
        .fwd_en     (wr_en),
        .fwd_pair   (wr_pair),
        .fwd_data   (wr_data),
        .rd_pair    (rd_pair),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    // sampled at the output clock rise, i.e. the second half of the prior period
    AST_RD_BURST_VALID: assert property (@(posedge rclk) disable iff (!rst_n)
        !rd_sel_n |-> ##2 dout_valid);  // R7
    AST_IDLE_NO_VALID: assert property (@(posedge rclk) disable iff (!rst_n)
        rd_sel_n |-> ##2 !dout_valid);  // R5
    AST_IDLE_HOLDS_DOUT: assert property (@(posedge rclk) disable iff (!rst_n)
        (!dout_valid && $past(!dout_valid)) |-> $stable(dout));  // R5
    AST_RESET_QUIET: assert property (@(posedge rclk)
        !rst_n |-> (!dout_valid && dout == '0));  // R9
endmodule

// File: tb/test_sio_burst_sram.sv
`timescale 1ns/1ps
module test_sio_burst_sram;
    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_sel_n, rd_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_valid;

    always #2 clk = ~clk;  // 250 MHz

    sio_burst_sram #(.ADDR_W(AW), .DATA_W(DW)) i_sio_burst_sram (
        .wclk       (clk),
        .wclk_n     (~clk),
        .rclk       (clk),
        .rclk_n     (~clk),
        .rst_n      (rst_n),
        .wr_sel_n   (wr_sel_n),
        .rd_sel_n   (rd_sel_n),
        .addr       (addr),
        .din        (din),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;
    logic [DW-1:0] ref_mem [NW];
    bit            pend;
    string         pend_tag;
    logic [DW-1:0] exp_lead, exp_trail, last_out;

    function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
        return a ^ AW'(1);
    endfunction

    function automatic logic [DW-1:0] ref_word(input logic [AW-1:0] a);
        return ref_mem[a];
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one period: entered 1 ns before the clock rise, leaves 1 ns before the next
    task automatic cycle(input bit rd, input logic [AW-1:0] ra, input bit wr,
                         input logic [AW-1:0] wa, input logic [DW-1:0] w0,
                         input logic [DW-1:0] w1, input string tag);
        rd_sel_n = !rd;
        wr_sel_n = !wr;
        addr     = ra;
        din      = w0;
        @(posedge clk);
        #1;
        if (pend) begin
            chk({pend_tag, "/R3 valid"}, DW'(dout_valid), DW'(1));
            chk({pend_tag, "/R3 lead"}, dout, exp_lead);
        end else begin
            chk("R5 idle valid", DW'(dout_valid), DW'(0));
            chk("R5 idle hold", dout, last_out);
        end
        addr = wa;
        din  = w1;
        #2;
        if (pend) begin
            chk({pend_tag, "/R4 valid"}, DW'(dout_valid), DW'(1));
            chk({pend_tag, "/R4 trail"}, dout, exp_trail);
            last_out = exp_trail;
        end else begin
            chk("R5 idle valid", DW'(dout_valid), DW'(0));
            chk("R5 idle hold", dout, last_out);
        end
        // R6: the model applies the write before evaluating the same-period read
        if (wr) begin
            ref_mem[wa]          = w0;
            ref_mem[partner(wa)] = w1;
        end
        pend     = rd;
        pend_tag = tag;
        if (rd) begin
            exp_lead  = ref_word(ra);
            exp_trail = ref_word(partner(ra));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        rst_n    = 1'b0;
        wr_sel_n = 1'b1;
        rd_sel_n = 1'b1;
        addr     = '0;
        din      = '0;
        pend     = 1'b0;
        pend_tag = "";
        last_out = '0;
        exp_lead = '0;
        exp_trail = '0;
        for (int i = 0; i < NW; i++) ref_mem[i] = '0;
        #7;
        chk("R9 reset valid", DW'(dout_valid), DW'(0));
        chk("R9 reset dout", dout, '0);
        #6;  // release at 13 ns: input clock is low, next edge is a rise
        rst_n = 1'b1;

        // R1: fill every pair, even addresses, write only
        for (int p = 0; p < NW / 2; p++) begin
            cycle(1'b0, '0, 1'b1, AW'(2 * p), DW'(16'h1000 + 2 * p), DW'(16'h1001 + 2 * p), "R1");
        end
        // R1: odd write address puts the first word on the odd slot
        cycle(1'b0, '0, 1'b1, AW'(7), 16'hA7A7, 16'hA6A6, "R1");
        cycle(1'b1, AW'(6), 1'b0, '0, '0, '0, "R1");
        // R4: odd read address wraps within its pair
        cycle(1'b1, AW'(7), 1'b0, '0, '0, '0, "R4");
        // R2: deasserted write select with junk on the buses
        cycle(1'b0, '0, 1'b0, AW'(20), 16'hDEAD, 16'hBEEF, "R2");
        cycle(1'b1, AW'(20), 1'b0, '0, '0, '0, "R2");
        // R6: read and write of the same pair in one period
        cycle(1'b1, AW'(11), 1'b1, AW'(10), 16'h5A5A, 16'hC3C3, "R6");
        cycle(1'b1, AW'(10), 1'b1, AW'(11), 16'h0F0F, 16'hF0F0, "R6");
        // R5: idle periods after a burst hold the last word
        cycle(1'b0, '0, 1'b0, '0, '0, '0, "R5");
        cycle(1'b0, '0, 1'b0, '0, '0, '0, "R5");
        // R7/R8: random traffic, read and write every period, crowded addresses
        for (int n = 0; n < 2000; n++) begin
            bit            rd = ($urandom % 4) != 0;
            bit            wr = ($urandom % 4) != 0;
            logic [AW-1:0] ra = AW'($urandom % 12);
            logic [AW-1:0] wa = AW'($urandom % 12);
            cycle(rd, ra, wr, wa, DW'($urandom), DW'($urandom), "R7");
        end
        // R7: sustained back-to-back reads and writes with no gap
        for (int n = 0; n < 64; n++) begin
            cycle(1'b1, AW'(n % NW), 1'b1, AW'((n + 3) % NW), DW'(n * 3), DW'(n * 5), "R7");
        end
        cycle(1'b0, '0, 1'b0, '0, '0, '0, "R5");
        cycle(1'b0, '0, 1'b0, '0, '0, '0, "R5");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule